// File: doc/BRIEF.md
# Stereo PDM Microphone Receiver

This block drives the clock for a pair of digital microphones and receives the one-bit pulse-density stream that both of them place on a single shared data wire. One microphone drives the wire while the microphone clock is high and the other drives it while the clock is low. Each microphone releases the wire to high impedance while its partner talks, so the receiver sees only one driver in each half-period. The receiver separates the two talkers into a left and a right one-bit stream, each with its own single-cycle valid strobe. Decimation, gain and pin routing are handled elsewhere.

The microphone clock is produced by dividing the system clock by an even ratio, which software chooses to match the converter sampling rate. Rather than sampling on the microphone clock transitions, the receiver samples the wire near the middle of each half-period, where the data is most stable. Raising `mic_en` makes this receiver the capture source in place of the conventional converter input. Dropping `mic_en` stops the clock and silences both streams. The raw input passes through a synchronizer, and the sampling point is placed in the divider count so that the synchronizer delay lands the sample at mid-phase.

The output streams carry a valid strobe but have no ready signal. A PDM source cannot be paused, so the consumer must accept every bit in the cycle it is flagged. No bit is held back, repeated or dropped for flow control. Control inputs are plain levels.

Top module: `pdm_stereo_rx`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `mic_clk`, `left_valid` and `right_valid` are 0.
- R2: The division ratio N is `clk_div` with bit 0 forced to 0, raised to 4 if that value is below 4. While running, `mic_clk` is high for N/2 system cycles and then low for N/2 cycles, repeating. N is taken when a run starts, and changes to `clk_div` during a run have no effect until the next start.
- R3: When `mic_en` is first sampled high at edge S (the clock being stopped), `mic_clk` is high in the cycle that follows S. The run therefore begins with a full high half-period.
- R4: Let Q = (N/2)/2. The value on `pdm_in` at edge S+Q+kN (k >= 0) appears on `left_bit`, with `left_valid` high for exactly one cycle, in the cycle following edge S+Q+2+kN.
- R5: The value on `pdm_in` at edge S+N/2+Q+kN appears on `right_bit`, with `right_valid` high for one cycle, in the cycle following edge S+N/2+Q+2+kN. This is exactly N/2 cycles after the matching left strobe.
- R6: After a start, the first strobe is a left strobe, and every right strobe is preceded by a left strobe of the same run. No partial first sample is produced.
- R7: In each cycle following an edge at which `mic_en` is sampled low, `mic_clk`, `left_valid` and `right_valid` are 0. `pdm_in` activity has no effect on them while disabled.
- R8: `left_valid` and `right_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mic_en | input | 1 | Selects the digital microphone path and runs the clock |
| clk_div | input | DIV_W | Requested system-to-microphone clock ratio |
| pdm_in | input | 1 | Shared microphone data wire (asynchronous) |
| mic_clk | output | 1 | Clock driven to both microphones |
| left_valid | output | 1 | One-cycle strobe: `left_bit` holds a new sample |
| left_bit | output | 1 | Sample taken during the high half-period |
| right_valid | output | 1 | One-cycle strobe: `right_bit` holds a new sample |
| right_bit | output | 1 | Sample taken during the low half-period |

## Verification
The bench drives random data on the wire and checks each strobe's bit against the exact pin value at the mid-phase edge. A receiver that sampled on the clock edges, or that ignored the synchronizer delay, would hand back a neighbouring bit and fail this check. Odd and too-small `clk_div` values are applied, and `clk_div` is changed in the middle of a run, to catch divider code that produces uneven halves or re-times the clock without a restart. The bench also disables the block in the middle of a half-period and enables it again. A design that left a stale strobe, resumed mid-period, or let a right strobe arrive before the first left one would be reported there.

// File: rtl/pdm_rx_pkg.sv
package pdm_rx_pkg;

  // Smallest division ratio that still leaves a mid-phase tick in each half
  localparam int MIN_RATIO = 4;

  // Number of talkers sharing the wire; lane 0 owns the high half-period
  localparam int NUM_LANES = 2;

  typedef struct packed {
    logic valid;
    logic data;
  } pdm_bit_t;

endpackage

// File: rtl/pdm_in_sync.sv
module pdm_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= din;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/pdm_clk_div.sv
module pdm_clk_div
  import pdm_rx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic [DIV_W-1:0]     div_i,
  output logic                 mic_clk_o,
  output logic                 run_o,
  output logic [NUM_LANES-1:0] tick_o
);

  localparam int CW = DIV_W + 1;

  logic             run_q;
  logic             hi_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] ratio_q;
  logic [DIV_W-1:0] ratio_req;
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] quarter;
  logic [DIV_W-1:0] cnt_nxt;
  logic [CW-1:0]    pos_l_raw;
  logic [CW-1:0]    pos_r_raw;
  logic [DIV_W-1:0] pos_l;
  logic [DIV_W-1:0] pos_r;

  // Even ratio, never below the minimum
  always_comb begin
    ratio_req = {div_i[DIV_W-1:1], 1'b0};
    if (ratio_req < DIV_W'(MIN_RATIO)) ratio_req = DIV_W'(MIN_RATIO);
  end

  assign half    = ratio_q >> 1;
  assign quarter = half >> 1;

  // Tick placed late by the synchronizer depth so that the bit leaving the
  // synchronizer was on the pin at the mid-phase edge
  assign pos_l_raw = CW'(quarter) + CW'(SYNC_STAGES - 1);
  assign pos_l     = (pos_l_raw >= CW'(ratio_q)) ? DIV_W'(pos_l_raw - CW'(ratio_q))
                                                 : DIV_W'(pos_l_raw);
  assign pos_r_raw = CW'(pos_l) + CW'(half);
  assign pos_r     = (pos_r_raw >= CW'(ratio_q)) ? DIV_W'(pos_r_raw - CW'(ratio_q))
                                                 : DIV_W'(pos_r_raw);

  assign cnt_nxt = (cnt_q == ratio_q - DIV_W'(1)) ? '0 : cnt_q + DIV_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      hi_q    <= 1'b0;
      cnt_q   <= '0;
      ratio_q <= DIV_W'(MIN_RATIO);
    end else if (!en_i) begin
      run_q   <= 1'b0;
      hi_q    <= 1'b0;
      cnt_q   <= '0;
    end else if (!run_q) begin
      run_q   <= 1'b1;
      hi_q    <= 1'b1;
      cnt_q   <= '0;
      ratio_q <= ratio_req;
    end else begin
      cnt_q   <= cnt_nxt;
      hi_q    <= (cnt_nxt < half);
    end
  end

  assign mic_clk_o = hi_q;
  assign run_o     = run_q;
  assign tick_o[0] = run_q && (cnt_q == pos_l);
  assign tick_o[1] = run_q && (cnt_q == pos_r);

  // R7: stopped clock after enable drops
  p_clk_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !mic_clk_o);

  // R3: a run opens with the high half-period
  p_start_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> hi_q);

  // R2: counter stays inside the latched ratio
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < ratio_q));

  // R2: the clock rises only at the period boundary
  p_rise_at_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && $rose(hi_q)) |-> (cnt_q == '0));

  // R2: latched ratio is frozen while running
  p_ratio_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> $stable(ratio_q));

endmodule

// File: rtl/pdm_lane_split.sv
module pdm_lane_split
  import pdm_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_i,
  input  logic                 run_i,
  input  logic [NUM_LANES-1:0] tick_i,
  input  logic                 bit_i,
  output pdm_bit_t [NUM_LANES-1:0] lane_o
);

  logic                 capture_ok;
  logic                 armed_q;
  logic [NUM_LANES-1:0] take;

  assign capture_ok = en_i && run_i;

  // Lane 0 needs no history; later lanes wait until lane 0 has fired
  always_comb begin
    take[0] = capture_ok && tick_i[0];
    for (int i = 1; i < NUM_LANES; i++) begin
      take[i] = capture_ok && tick_i[i] && armed_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           armed_q <= 1'b0;
    else if (!capture_ok) armed_q <= 1'b0;
    else if (take[0])     armed_q <= 1'b1;
  end

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      logic v_q;
      logic d_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= 1'b0;
        end else begin
          v_q <= take[g];
          if (take[g]) d_q <= bit_i;
        end
      end
      assign lane_o[g].valid = v_q;
      assign lane_o[g].data  = d_q;
    end
  endgenerate

  // R8: the two talkers never complete in the same cycle
  p_one_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lane_o[1].valid, lane_o[0].valid}));

  // R6: a right strobe needs a left strobe earlier in the run
  p_right_after_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lane_o[1].valid |-> armed_q);

  // R7: no strobe unless enable was seen at the capturing edge
  p_strobe_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_o[0].valid || lane_o[1].valid) |-> $past(en_i));

endmodule

// File: rtl/pdm_stereo_rx.sv
module pdm_stereo_rx
  import pdm_rx_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mic_en,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             pdm_in,
  output logic             mic_clk,
  output logic             left_valid,
  output logic             left_bit,
  output logic             right_valid,
  output logic             right_bit
);

  logic                     pin_s;
  logic                     run;
  logic [NUM_LANES-1:0]     tick;
  pdm_bit_t [NUM_LANES-1:0] lane;

  pdm_in_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (pdm_in),
    .dout  (pin_s)
  );

  pdm_clk_div #(
    .DIV_W       (DIV_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (mic_en),
    .div_i     (clk_div),
    .mic_clk_o (mic_clk),
    .run_o     (run),
    .tick_o    (tick)
  );

  pdm_lane_split u_split (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (mic_en),
    .run_i  (run),
    .tick_i (tick),
    .bit_i  (pin_s),
    .lane_o (lane)
  );

  assign left_valid  = lane[0].valid;
  assign left_bit    = lane[0].data;
  assign right_valid = lane[1].valid;
  assign right_bit   = lane[1].data;

  // R4: left strobes only come while the microphone clock is running
  p_left_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    left_valid |-> $past(run));

endmodule

// File: tb/tb_pdm_stereo_rx.sv
module tb_pdm_stereo_rx;

  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mic_en = 1'b0;
  logic [DIV_W-1:0] clk_div = 8'd4;
  logic             pdm_in = 1'b0;
  logic             mic_clk, left_valid, left_bit, right_valid, right_bit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pdm_stereo_rx #(.DIV_W(DIV_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .mic_en(mic_en), .clk_div(clk_div),
    .pdm_in(pdm_in), .mic_clk(mic_clk), .left_valid(left_valid),
    .left_bit(left_bit), .right_valid(right_valid), .right_bit(right_bit)
  );

  // ---------------- reference model ----------------
  bit m_run = 0;
  int m_age = 0;
  int m_n   = 4;
  bit p0 = 0, p1 = 0, p2 = 0;
  bit e_clk = 0, e_lv = 0, e_rv = 0, e_dat = 0;
  bit m_active = 0;
  bit saw_left = 0;

  function automatic int eff_ratio(int d);
    int e;
    e = d & ~1;
    if (e < 4) e = 4;
    return e;
  endfunction

  always @(posedge clk) begin
    int half, q, x;
    p2 = p1; p1 = p0; p0 = pdm_in;
    if (!rst_n) begin
      m_run = 0; m_active = 0;
      e_clk = 0; e_lv = 0; e_rv = 0;
    end else begin
      m_active = 1;
      if (!mic_en) m_run = 0;
      else if (!m_run) begin m_run = 1; m_age = 0; m_n = eff_ratio(int'(clk_div)); end
      else m_age++;
      half = m_n / 2;
      q    = half / 2;
      x    = m_age - (q + 2);
      e_clk = m_run && ((m_age % m_n) < half);
      e_lv  = m_run && (x >= 0) && (x % m_n == 0);
      e_rv  = m_run && (x >= half) && ((x - half) % m_n == 0);
      e_dat = p2;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rst_n || !m_active) begin
      check("R1", "mic_clk in reset", mic_clk, 0);
      check("R1", "left_valid in reset", left_valid, 0);
      check("R1", "right_valid in reset", right_valid, 0);
    end else if (!m_run) begin
      check("R7", "mic_clk disabled", mic_clk, 0);
      check("R7", "left_valid disabled", left_valid, 0);
      check("R7", "right_valid disabled", right_valid, 0);
      saw_left = 0;
    end else begin
      if (m_age == 0) check("R3", "mic_clk at start", mic_clk, 1);
      else            check("R2", "mic_clk shape", mic_clk, e_clk);
      check("R4", "left_valid timing", left_valid, e_lv);
      check("R5", "right_valid timing", right_valid, e_rv);
      if (e_lv) check("R4", "left_bit value", left_bit, e_dat);
      if (e_rv) check("R5", "right_bit value", right_bit, e_dat);
      check("R8", "strobes exclusive", int'(left_valid && right_valid), 0);
      if (right_valid) check("R6", "right after left", saw_left, 1);
      if (left_valid) saw_left = 1;
    end
  end

  // random data on the shared wire
  always @(negedge clk) pdm_in = 1'($urandom);

  task automatic run_for(int div, int cyc);
    @(negedge clk);
    clk_div = DIV_W'(div);
    mic_en  = 1'b1;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic stop_for(int cyc);
    @(negedge clk);
    mic_en = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);          // R7: idle with toggling pin
    run_for(4, 60);                     // R4 R5 at the smallest ratio
    clk_div = 8'd10;                    // R2: ignored until restart
    repeat (40) @(negedge clk);
    stop_for(3);
    run_for(10, 83);
    stop_for(1);
    run_for(6, 81);                     // quarter of an odd half
    stop_for(2);
    run_for(3, 41);                     // R2: odd, rounds to 4
    stop_for(2);
    run_for(0, 30);                     // R2: below minimum
    stop_for(4);
    run_for(9, 87);                     // R2: rounds to 8
    stop_for(2);
    run_for(14, 95);
    stop_for(1);
    run_for(255, 700);                  // largest ratio
    stop_for(5);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule